// File: doc/BRIEF.md
# Port Fault Supervisor with Dwell Timers

This block watches a single powered Ethernet port once power has been granted. Each cycle it compares the measured current code against three limits. The low limit detects a missing load. The mid limit detects an overload, and its value is chosen by the AF/AT mode. The high limit detects a short. Each comparison has its own dwell counter, which counts coarse ticks from a built-in prescaler. A condition that lasts longer than its programmed dwell removes power and records a cause code. Two hazard flags, one for junction over-temperature and one for supply over-voltage, remove power on the next clock edge with no dwell.

An overload or no-load shutdown starts a recovery wait, and each cause has its own programmed length. When the wait ends, the block raises a one-cycle recovery request and returns to the off state. If the power request from the upstream sequencer is still high, the port is powered again. A short circuit latches the port off until the power request is withdrawn. A hazard flag keeps the port off for as long as the flag is raised.

Top module: `port_fault_supervisor`

## Requirements
- R1: After reset, port_en is 0, fault_cause is 0 and recover_req is 0.
- R2: While off, a high power_req with both hazard flags low turns port_en on at the next edge and clears fault_cause to 0. Dropping power_req while on turns the port off at the next edge.
- R3: A tick occurs once every TICK_DIV cycles. If cur_code >= ilim_code while the port is on, the port is switched off at the tick on which that condition has lasted more than tlim_ticks ticks, and fault_cause becomes 3 (short). The port then stays off until power_req has been low for at least one cycle.
- R4: If cur_code exceeds the overload limit for more than tcut_ticks ticks, the port is switched off with fault_cause 2 (overload). The overload limit is icut_af_code when mode_at = 0 and icut_at_code when mode_at = 1. A current between the two limits has no effect in AT mode.
- R5: If cur_code < imin_code for more than tmin_ticks ticks, the port is switched off with fault_cause 1 (no-load).
- R6: A dwell counter returns to zero whenever its condition is absent at any clock edge, so time on either side of a gap is never added together.
- R7: overtemp switches the port off at the next edge with fault_cause 5. supply_ov does the same with fault_cause 4. While either flag is high, power_req does not turn the port on. A flag raised during a recovery wait cancels that wait, and no recover_req is raised.
- R8: When several faults are present in the same cycle, fault_cause takes the highest-priority cause, in the order 5, then 4, then 3, then 2, then 1.
- R9: After an overload shutdown, recover_req pulses for one cycle once more than ovl_rec_ticks ticks have passed, and the block returns to off. During the wait, power_req is ignored.
- R10: After a no-load shutdown, the wait before recover_req is governed by nl_rec_ticks instead of ovl_rec_ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_req | input | 1 | Power grant from the port sequencer |
| mode_at | input | 1 | 1 selects the AT overload limit, 0 selects the AF limit |
| cur_code | input | CUR_W | Measured port current code |
| imin_code | input | CUR_W | No-load threshold |
| icut_af_code | input | CUR_W | Overload threshold in AF mode |
| icut_at_code | input | CUR_W | Overload threshold in AT mode |
| ilim_code | input | CUR_W | Short-circuit threshold |
| tlim_ticks | input | TIM_W | Short dwell in ticks |
| tcut_ticks | input | TIM_W | Overload dwell in ticks |
| tmin_ticks | input | TIM_W | No-load dwell in ticks |
| ovl_rec_ticks | input | TIM_W | Wait after an overload shutdown |
| nl_rec_ticks | input | TIM_W | Wait after a no-load shutdown |
| overtemp | input | 1 | Junction over-temperature flag |
| supply_ov | input | 1 | Main supply over-voltage flag |
| port_en | output | 1 | Port power switch enable |
| fault_cause | output | 3 | Last shutdown cause (0 none, 1 no-load, 2 overload, 3 short, 4 supply, 5 thermal) |
| recover_req | output | 1 | One-cycle recovery attempt request |

## Verification
A current at or above the short limit is also above the overload limit. When both dwell settings are equal, the short and overload counters start on the same edge and expire on the same tick. The bench sets up this collision and expects cause 3 inside the shared timing window. In a second collision, both hazard flags are raised together with a short-level current, and the cause must be 5 on the very next edge. Each timed shutdown is judged against a window of edges. The window is derived from the dwell setting and the prescaler period, and it covers every possible tick phase.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_NOLOAD    = 3'd1,
        CAUSE_OVERLOAD  = 3'd2,
        CAUSE_SHORT     = 3'd3,
        CAUSE_SUPPLY_OV = 3'd4,
        CAUSE_OVERTEMP  = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_ON   = 2'd1,
        PS_WAIT = 2'd2,
        PS_HOLD = 2'd3
    } pstate_e;

    localparam int NUM_TIMERS = 4;
    localparam int TMR_SHORT  = 0;
    localparam int TMR_OVL    = 1;
    localparam int TMR_NOLOAD = 2;
    localparam int TMR_REC    = 3;

endpackage

// File: rtl/pfs_tick_gen.sv
module pfs_tick_gen #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // ticks never come back to back when the divider exceeds one
            assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pfs_dwell_timer.sv
module pfs_dwell_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cond,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam logic [TW-1:0] CMAX = '1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!cond)
            cnt_d = '0;
        else if (tick && (cnt_q != CMAX))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // expiry: condition still present on a tick after more than limit ticks
    assign expire = cond && tick && (cnt_q >= limit);

    assert_gap_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt_q == '0));

    assert_count_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/port_fault_supervisor.sv
module port_fault_supervisor
    import pfs_pkg::*;
#(
    parameter int CUR_W    = 10,
    parameter int TIM_W    = 12,
    parameter int TICK_DIV = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_req,
    input  logic             mode_at,
    input  logic [CUR_W-1:0] cur_code,
    input  logic [CUR_W-1:0] imin_code,
    input  logic [CUR_W-1:0] icut_af_code,
    input  logic [CUR_W-1:0] icut_at_code,
    input  logic [CUR_W-1:0] ilim_code,
    input  logic [TIM_W-1:0] tlim_ticks,
    input  logic [TIM_W-1:0] tcut_ticks,
    input  logic [TIM_W-1:0] tmin_ticks,
    input  logic [TIM_W-1:0] ovl_rec_ticks,
    input  logic [TIM_W-1:0] nl_rec_ticks,
    input  logic             overtemp,
    input  logic             supply_ov,
    output logic             port_en,
    output logic [2:0]       fault_cause,
    output logic             recover_req
);
    typedef struct packed {
        pstate_e state;
        cause_e  cause;
        logic    recover;
    } regs_t;

    regs_t r_d, r_q;

    logic                  tick;
    logic [NUM_TIMERS-1:0] cond;
    logic [NUM_TIMERS-1:0] expire;
    logic [TIM_W-1:0]      limit [NUM_TIMERS];
    logic [CUR_W-1:0]      icut_sel;
    logic                  hot;
    cause_e                hot_cause;
    logic                  is_on;

    pfs_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign icut_sel  = mode_at ? icut_at_code : icut_af_code;
    assign is_on     = (r_q.state == PS_ON);
    assign hot       = overtemp || supply_ov;
    assign hot_cause = overtemp ? CAUSE_OVERTEMP : CAUSE_SUPPLY_OV;

    always_comb begin
        cond[TMR_SHORT]   = is_on && (cur_code >= ilim_code);
        cond[TMR_OVL]     = is_on && (cur_code >  icut_sel);
        cond[TMR_NOLOAD]  = is_on && (cur_code <  imin_code);
        cond[TMR_REC]     = (r_q.state == PS_WAIT);
        limit[TMR_SHORT]  = tlim_ticks;
        limit[TMR_OVL]    = tcut_ticks;
        limit[TMR_NOLOAD] = tmin_ticks;
        limit[TMR_REC]    = (r_q.cause == CAUSE_OVERLOAD) ? ovl_rec_ticks : nl_rec_ticks;
    end

    generate
        for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
            pfs_dwell_timer #(.TW(TIM_W)) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .cond   (cond[g]),
                .limit  (limit[g]),
                .expire (expire[g])
            );
        end
    endgenerate

    always_comb begin
        r_d         = r_q;
        r_d.recover = 1'b0;
        unique case (r_q.state)
            PS_OFF: begin
                if (power_req) begin
                    if (hot) begin
                        r_d.cause = hot_cause;
                    end else begin
                        r_d.state = PS_ON;
                        r_d.cause = CAUSE_NONE;
                    end
                end
            end
            PS_ON: begin
                if (hot) begin
                    r_d.state = PS_OFF;
                    r_d.cause = hot_cause;
                end else if (expire[TMR_SHORT]) begin
                    r_d.state = PS_HOLD;
                    r_d.cause = CAUSE_SHORT;
                end else if (expire[TMR_OVL]) begin
                    r_d.state = PS_WAIT;
                    r_d.cause = CAUSE_OVERLOAD;
                end else if (expire[TMR_NOLOAD]) begin
                    r_d.state = PS_WAIT;
                    r_d.cause = CAUSE_NOLOAD;
                end else if (!power_req) begin
                    r_d.state = PS_OFF;
                end
            end
            PS_WAIT: begin
                if (hot) begin
                    r_d.state = PS_OFF;
                    r_d.cause = hot_cause;
                end else if (expire[TMR_REC]) begin
                    r_d.state   = PS_OFF;
                    r_d.recover = 1'b1;
                end
            end
            PS_HOLD: begin
                if (!power_req) r_d.state = PS_OFF;
            end
            default: r_d.state = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PS_OFF, cause: CAUSE_NONE, recover: 1'b0};
        else        r_q <= r_d;
    end

    assign port_en     = (r_q.state == PS_ON);
    assign fault_cause = r_q.cause;
    assign recover_req = r_q.recover;

    assert_on_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_en) |-> (fault_cause == CAUSE_NONE));

    assert_short_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_on && !hot && expire[TMR_SHORT]) |=> (!port_en && fault_cause == CAUSE_SHORT));

    assert_hold_until_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_HOLD && power_req) |=> !port_en);

    assert_refuse_when_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> !port_en);

    assert_thermal_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overtemp && is_on) |=> (fault_cause == CAUSE_OVERTEMP));

    assert_recover_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |=> !recover_req);

    assert_recover_from_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> ($past(r_q.state) == PS_WAIT));

endmodule

// File: tb/port_fault_supervisor_tb_top.sv
module port_fault_supervisor_tb_top;
    localparam int CUR_W = 10;
    localparam int TIM_W = 12;
    localparam int P     = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             power_req = 1'b0;
    logic             mode_at = 1'b0;
    logic [CUR_W-1:0] cur_code = 10'd200;
    logic [CUR_W-1:0] imin_code = 10'd20;
    logic [CUR_W-1:0] icut_af_code = 10'd350;
    logic [CUR_W-1:0] icut_at_code = 10'd600;
    logic [CUR_W-1:0] ilim_code = 10'd850;
    logic [TIM_W-1:0] tlim_ticks = 12'd2;
    logic [TIM_W-1:0] tcut_ticks = 12'd5;
    logic [TIM_W-1:0] tmin_ticks = 12'd8;
    logic [TIM_W-1:0] ovl_rec_ticks = 12'd6;
    logic [TIM_W-1:0] nl_rec_ticks = 12'd3;
    logic             overtemp = 1'b0;
    logic             supply_ov = 1'b0;
    logic             port_en;
    logic [2:0]       fault_cause;
    logic             recover_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int    kind;   // 0 = shutdown watch, 1 = recovery watch
        int    cause;
        int    kmin;
        int    kmax;
        string req;
    } item_t;

    item_t sb[$];
    int    k = 0;

    always #10 clk = ~clk;

    port_fault_supervisor #(.CUR_W(CUR_W), .TIM_W(TIM_W), .TICK_DIV(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .power_req(power_req), .mode_at(mode_at),
        .cur_code(cur_code), .imin_code(imin_code), .icut_af_code(icut_af_code),
        .icut_at_code(icut_at_code), .ilim_code(ilim_code), .tlim_ticks(tlim_ticks),
        .tcut_ticks(tcut_ticks), .tmin_ticks(tmin_ticks), .ovl_rec_ticks(ovl_rec_ticks),
        .nl_rec_ticks(nl_rec_ticks), .overtemp(overtemp), .supply_ov(supply_ov),
        .port_en(port_en), .fault_cause(fault_cause), .recover_req(recover_req)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // dwell of L ticks expires between L*P+1 and (L+1)*P edges after the stimulus
    task automatic expect_item(input int kind, input int cause, input int lim, input string req);
        item_t it;
        it.kind  = kind;
        it.cause = cause;
        it.kmin  = (lim < 0) ? 1 : lim * P + 1;
        it.kmax  = (lim < 0) ? 1 : (lim + 1) * P;
        it.req   = req;
        k = 0;
        sb.push_back(it);
    endtask

    task automatic wait_done();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() != 0) begin
                k++;
                if (sb[0].kind == 0) begin
                    if (!port_en) begin
                        check(sb[0].req, k >= sb[0].kmin && k <= sb[0].kmax, 1, "shutdown edge in window");
                        check(sb[0].req, fault_cause, sb[0].cause, "fault cause");
                        void'(sb.pop_front());
                    end else if (k > sb[0].kmax) begin
                        check(sb[0].req, port_en, 0, "no shutdown by window end");
                        void'(sb.pop_front());
                    end
                end else begin
                    if (port_en) begin
                        check(sb[0].req, port_en, 0, "port stays off during wait");
                        void'(sb.pop_front());
                    end else if (recover_req) begin
                        check(sb[0].req, k >= sb[0].kmin && k <= sb[0].kmax, 1, "recovery edge in window");
                        void'(sb.pop_front());
                    end else if (k > sb[0].kmax) begin
                        check(sb[0].req, recover_req, 1, "no recovery by window end");
                        void'(sb.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R1", port_en, 0, "port_en after reset");
        check("R1", fault_cause, 0, "cause after reset");
        check("R1", recover_req, 0, "recover_req after reset");
        rst_n = 1'b1;
        idle(2);

        // R2 power on
        power_req = 1'b1;
        @(negedge clk);
        check("R2", port_en, 1, "port on after request");
        check("R2", fault_cause, 0, "cause clear at power on");
        power_req = 1'b0;
        @(negedge clk);
        check("R2", port_en, 0, "port off after request drop");
        power_req = 1'b1;
        @(negedge clk);

        // R3 short, then latched off while request held
        cur_code = 10'd900;
        expect_item(0, 3, 2, "R3");
        wait_done();
        cur_code = 10'd200;
        idle(20);
        check("R3", port_en, 0, "short latch holds with request high");
        power_req = 1'b0;
        @(negedge clk);
        power_req = 1'b1;
        @(negedge clk);
        check("R3", port_en, 1, "power again after release");

        // R4 overload in AF mode, then R9 recovery
        cur_code = 10'd400;
        expect_item(0, 2, 5, "R4");
        wait_done();
        cur_code = 10'd200;
        expect_item(1, 0, 6, "R9");
        wait_done();
        @(negedge clk);
        check("R9", port_en, 1, "re-powered after overload recovery");
        check("R9", fault_cause, 0, "cause cleared on re-power");

        // R4 AT mode: 400 has no effect, 650 overloads
        mode_at  = 1'b1;
        cur_code = 10'd400;
        idle(60);
        check("R4", port_en, 1, "AT mode ignores current below AT limit");
        cur_code = 10'd650;
        expect_item(0, 2, 5, "R4");
        wait_done();
        cur_code = 10'd200;
        expect_item(1, 0, 6, "R9");
        wait_done();
        mode_at = 1'b0;
        @(negedge clk);

        // R5 no-load, R10 its own recovery wait
        cur_code = 10'd5;
        expect_item(0, 1, 8, "R5");
        wait_done();
        cur_code = 10'd200;
        expect_item(1, 0, 3, "R10");
        wait_done();
        @(negedge clk);
        check("R10", port_en, 1, "re-powered after no-load recovery");

        // R6 a single clean sample restarts the overload dwell
        cur_code = 10'd400;
        idle(15);
        check("R6", port_en, 1, "no overload before full dwell");
        cur_code = 10'd200;
        @(negedge clk);
        cur_code = 10'd400;
        expect_item(0, 2, 5, "R6");
        wait_done();
        cur_code = 10'd200;
        expect_item(1, 0, 6, "R9");
        wait_done();
        @(negedge clk);

        // R7 thermal: immediate, and refusal while set
        overtemp = 1'b1;
        expect_item(0, 5, -1, "R7");
        wait_done();
        idle(10);
        check("R7", port_en, 0, "no power while thermal flag set");
        overtemp = 1'b0;
        @(negedge clk);
        check("R7", port_en, 1, "power after thermal flag clears");
        supply_ov = 1'b1;
        expect_item(0, 4, -1, "R7");
        wait_done();
        supply_ov = 1'b0;
        @(negedge clk);

        // R8 both flags plus short-level current in one cycle
        overtemp  = 1'b1;
        supply_ov = 1'b1;
        cur_code  = 10'd900;
        expect_item(0, 5, -1, "R8");
        wait_done();
        overtemp  = 1'b0;
        supply_ov = 1'b0;
        cur_code  = 10'd200;
        @(negedge clk);
        check("R8", port_en, 1, "back on after flags clear");

        // R8 short and overload expiring on the same tick
        tcut_ticks = 12'd3;
        tlim_ticks = 12'd3;
        cur_code   = 10'd900;
        expect_item(0, 3, 3, "R8");
        wait_done();
        cur_code   = 10'd200;
        tcut_ticks = 12'd5;
        power_req  = 1'b0;
        @(negedge clk);
        power_req  = 1'b1;
        @(negedge clk);

        // R7 supply flag during overload wait cancels recovery
        cur_code = 10'd400;
        expect_item(0, 2, 5, "R4");
        wait_done();
        cur_code  = 10'd200;
        supply_ov = 1'b1;
        @(negedge clk);
        check("R7", fault_cause, 4, "flag overrides wait cause");
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (recover_req) seen = 1'b1;
            end
            check("R7", seen, 0, "no recovery request after flag");
        end
        supply_ov = 1'b0;
        @(negedge clk);
        check("R7", port_en, 1, "powered after flag clears");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule